// File: doc/BRIEF.md
# String Instruction Sequencer

This block is a multi-cycle engine that carries out one block-string instruction at a time over a simple memory port. The memory port moves bytes, halfwords or words and answers each request with an acknowledge. The engine works on three working registers. R1 is the destination or scan pointer. R2 is either the source pointer or the value to compare against. R3 holds the element count. A caller loads the three registers together with an operation and an element size, pulses `start`, and waits for `done`. It then reads back the updated registers and, for the scanning and comparing operations, the zero and carry flags.

There are seven operations: copy forward, copy backward, copy until a zero byte, fill, search until equal, search while equal, and string compare. All seven share one count and pointer datapath. They differ in their termination rule, their pointer direction and the formula that produces the flags. Only one memory access is ever in flight. The engine holds a request, with a stable address, until that request is acknowledged.

Top module: `strseq_engine`

## Requirements
- R1: A start with `size` = 3 or `op` = 7 gives `done` one cycle later with `err` = 1. It makes no memory request and changes neither the memory nor the flags. The register outputs show the loaded inputs. The next legal start clears `err`.
- R2: A legal start with R3 = 0 gives `done` one cycle later with `err` = 0. It makes no memory request. The register outputs equal the inputs and the flags keep their values.
- R3: Copy forward (`op` = 0) and copy backward (`op` = 1) repeat the following steps until R3 reaches 0:
  - read a byte at R2;
  - write that byte at R1;
  - step R1 and R2 by +1 (forward) or -1 (backward);
  - decrement R3 by one for each element completed.
- R4: Copy-until-zero (`op` = 2) copies forward like R3, but also ends right after the write of a zero byte.
- R5: Fill (`op` = 3) writes the low 1, 2 or 4 bytes of R2 at R1, for `size` = 0, 1 or 2 respectively. It advances R1 by 1 << `size` and decrements R3 until R3 is 0. R2 is unchanged. Memory is little-endian: byte k of a datum sits at address + k.
- R6: Search-until-equal (`op` = 4) works as follows:
  - it loads the zero-extended element of `size` at R1, advances R1 by the element size and decrements R3;
  - it ends when the element equals R2 or when R3 reaches 0;
  - at the end, Z = (element == R2) and C = (element <= R2, unsigned).
- R7: Search-while-equal (`op` = 5) steps like R6 but ends on the first element that differs from R2, or when R3 reaches 0. At the end, Z = (remaining R3 == 0) and C = (element <= R2, unsigned).
- R8: Compare (`op` = 6) works as follows:
  - it reads byte A at R1 and byte B at R2, increments both pointers and decrements R3;
  - it ends when A differs from B, when A is 0, or when R3 reaches 0;
  - at the end, Z = (A == B) and C = (A >= B, unsigned).
- R9: At most one memory request is outstanding at a time. The request stays high, with a stable address and direction, until `mem_ack`. No request is made while the engine is idle.
- R10: Further properties of `done`, the flags and reset:
  - `done` is a one-cycle pulse;
  - the copy and fill operations leave `flag_z` and `flag_c` unchanged;
  - reset clears the registers, the flags, `err`, `busy` and `mem_req`;
  - `start` is taken only while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (taken when idle) |
| op | input | 3 | Operation code, see R3 to R8 |
| size | input | 2 | Element size code: 0 byte, 1 halfword, 2 word, 3 illegal |
| r1_in | input | XLEN | Initial R1 |
| r2_in | input | XLEN | Initial R2 |
| r3_in | input | XLEN | Initial R3 |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last instruction was illegal |
| r1_out | output | XLEN | Current R1 |
| r2_out | output | XLEN | Current R2 |
| r3_out | output | XLEN | Current R3 |
| flag_z | output | 1 | Result-is-zero flag |
| flag_c | output | 1 | Carry flag |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_size | output | 2 | Access size code |
| mem_addr | output | XLEN | Access address |
| mem_wdata | output | XLEN | Write data, low bytes used |
| mem_ack | input | 1 | Request accepted; read data valid this cycle |
| mem_rdata | input | XLEN | Read data, low bytes used |

## Verification
The assertions assume that the memory raises `mem_ack` only for one cycle, and only while `mem_req` is high. They also assume that `start` is offered only while `busy` is low, because the one-cycle completion checks for R1 and R2 are keyed to an idle start. The bench keeps to both assumptions. It models the memory inside its own stimulus loop, acknowledging each request after a per-vector latency of 0 to 2 cycles and then dropping `mem_ack` for at least one cycle. It issues each new `start` only after the previous `done` has been seen.

// File: rtl/strseq_pkg.sv
package strseq_pkg;

  typedef enum logic [2:0] {
    OP_CPY_FWD = 3'd0,
    OP_CPY_BWD = 3'd1,
    OP_CPY_NUL = 3'd2,
    OP_FILL    = 3'd3,
    OP_SRCH_EQ = 3'd4,
    OP_SRCH_NE = 3'd5,
    OP_CMP     = 3'd6,
    OP_BAD     = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    SZ_B   = 2'd0,
    SZ_H   = 2'd1,
    SZ_W   = 2'd2,
    SZ_BAD = 2'd3
  } sz_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDA,
    ST_RDB,
    ST_WR,
    ST_FIN
  } st_e;

  function automatic logic op_is_copy(input op_e o);
    return o inside {OP_CPY_FWD, OP_CPY_BWD, OP_CPY_NUL};
  endfunction

  function automatic logic op_is_search(input op_e o);
    return o inside {OP_SRCH_EQ, OP_SRCH_NE};
  endfunction

  function automatic logic op_is_illegal(input op_e o, input sz_e s);
    return (o == OP_BAD) || (s == SZ_BAD);
  endfunction

endpackage

// File: rtl/strseq_step.sv
// Next-element pointer and count arithmetic shared by every operation.
module strseq_step
  import strseq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  op_e             op,
  input  sz_e             sz,
  input  logic [XLEN-1:0] r1,
  input  logic [XLEN-1:0] r2,
  input  logic [XLEN-1:0] r3,
  output logic [XLEN-1:0] r1_nxt,
  output logic [XLEN-1:0] r2_nxt,
  output logic [XLEN-1:0] r3_nxt
);

  // Signed stride of the scan pointer, in two's complement.
  function automatic logic [XLEN-1:0] stride_of(input op_e o, input sz_e s);
    case (o)
      OP_CPY_BWD:                        return '1;
      OP_FILL, OP_SRCH_EQ, OP_SRCH_NE:   return XLEN'(1) << s;
      default:                           return XLEN'(1);
    endcase
  endfunction

  function automatic logic src_moves(input op_e o);
    return op_is_copy(o) || (o == OP_CMP);
  endfunction

  logic [XLEN-1:0] stride;

  always_comb begin
    stride = stride_of(op, sz);
    r1_nxt = r1 + stride;
    r2_nxt = src_moves(op) ? (r2 + stride) : r2;
    r3_nxt = r3 - XLEN'(1);
  end

endmodule

// File: rtl/strseq_judge.sv
// Termination rule and flag formula for the element just completed.
module strseq_judge
  import strseq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  op_e             op,
  input  sz_e             sz,
  input  logic [XLEN-1:0] elem_a,
  input  logic [7:0]      byte_b,
  input  logic [XLEN-1:0] r2,
  input  logic [XLEN-1:0] r3_nxt,
  output logic            stop,
  output logic            z_val,
  output logic            c_val,
  output logic            upd_flags
);

  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;

  function automatic logic [XLEN-1:0] zext(input logic [XLEN-1:0] d, input sz_e s);
    case (s)
      SZ_B:    return {{(XLEN-BYTE_W){1'b0}}, d[BYTE_W-1:0]};
      SZ_H:    return {{(XLEN-HALF_W){1'b0}}, d[HALF_W-1:0]};
      default: return d;
    endcase
  endfunction

  logic [XLEN-1:0]   elem;
  logic [BYTE_W-1:0] byte_a;
  logic              cnt_out;
  logic              hit;

  always_comb begin
    elem      = zext(elem_a, sz);
    byte_a    = elem_a[BYTE_W-1:0];
    cnt_out   = (r3_nxt == '0);
    hit       = (elem == r2);
    stop      = cnt_out;
    z_val     = 1'b0;
    c_val     = 1'b0;
    upd_flags = 1'b0;
    case (op)
      OP_CPY_NUL: stop = cnt_out || (byte_a == '0);
      OP_SRCH_EQ: begin
        stop      = cnt_out || hit;
        z_val     = hit;
        c_val     = (elem <= r2);
        upd_flags = 1'b1;
      end
      OP_SRCH_NE: begin
        stop      = cnt_out || !hit;
        z_val     = cnt_out;
        c_val     = (elem <= r2);
        upd_flags = 1'b1;
      end
      OP_CMP: begin
        stop      = cnt_out || (byte_a != byte_b) || (byte_a == '0);
        z_val     = (byte_a == byte_b);
        c_val     = (byte_a >= byte_b);
        upd_flags = 1'b1;
      end
      default: stop = cnt_out;
    endcase
  end

endmodule

// File: rtl/strseq_engine.sv
module strseq_engine
  import strseq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2:0]      op,
  input  logic [1:0]      size,
  input  logic [XLEN-1:0] r1_in,
  input  logic [XLEN-1:0] r2_in,
  input  logic [XLEN-1:0] r3_in,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic [XLEN-1:0] r1_out,
  output logic [XLEN-1:0] r2_out,
  output logic [XLEN-1:0] r3_out,
  output logic            flag_z,
  output logic            flag_c,
  output logic            mem_req,
  output logic            mem_we,
  output logic [1:0]      mem_size,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic            mem_ack,
  input  logic [XLEN-1:0] mem_rdata
);

  localparam int BYTE_W = 8;

  st_e             st_q;
  op_e             op_q;
  sz_e             sz_q;
  logic [XLEN-1:0] r1_q, r2_q, r3_q;
  logic [XLEN-1:0] hold_a;
  logic            z_q, c_q, err_q;

  op_e             op_new;
  sz_e             sz_new;
  logic            bad_new;

  logic [XLEN-1:0] r1_nxt, r2_nxt, r3_nxt;
  logic [XLEN-1:0] a_src;
  logic            stop, z_val, c_val, upd_flags;

  // Named internal events, observed by the bound checker.
  logic            elem_done;
  logic            flag_upd;

  assign op_new  = op_e'(op);
  assign sz_new  = sz_e'(size);
  assign bad_new = op_is_illegal(op_new, sz_new);

  assign a_src = (st_q == ST_RDA) ? mem_rdata : hold_a;

  strseq_step #(.XLEN(XLEN)) step_i (
    .op     (op_q),
    .sz     (sz_q),
    .r1     (r1_q),
    .r2     (r2_q),
    .r3     (r3_q),
    .r1_nxt (r1_nxt),
    .r2_nxt (r2_nxt),
    .r3_nxt (r3_nxt)
  );

  strseq_judge #(.XLEN(XLEN)) judge_i (
    .op        (op_q),
    .sz        (sz_q),
    .elem_a    (a_src),
    .byte_b    (mem_rdata[BYTE_W-1:0]),
    .r2        (r2_q),
    .r3_nxt    (r3_nxt),
    .stop      (stop),
    .z_val     (z_val),
    .c_val     (c_val),
    .upd_flags (upd_flags)
  );

  assign elem_done = mem_ack && (((st_q == ST_RDA) && op_is_search(op_q)) ||
                                 (st_q == ST_RDB) || (st_q == ST_WR));
  assign flag_upd  = elem_done && stop && upd_flags;

  // Memory port drive.
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_size  = SZ_B;
    mem_addr  = r1_q;
    mem_wdata = (op_q == OP_FILL) ? r2_q : {{(XLEN-BYTE_W){1'b0}}, hold_a[BYTE_W-1:0]};
    case (st_q)
      ST_RDA: begin
        mem_req  = 1'b1;
        mem_addr = op_is_copy(op_q) ? r2_q : r1_q;
        mem_size = op_is_search(op_q) ? sz_q : SZ_B;
      end
      ST_RDB: begin
        mem_req  = 1'b1;
        mem_addr = r2_q;
      end
      ST_WR: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_size = (op_q == OP_FILL) ? sz_q : SZ_B;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_CPY_FWD;
      sz_q   <= SZ_B;
      r1_q   <= '0;
      r2_q   <= '0;
      r3_q   <= '0;
      hold_a <= '0;
      z_q    <= 1'b0;
      c_q    <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            op_q  <= op_new;
            sz_q  <= sz_new;
            r1_q  <= r1_in;
            r2_q  <= r2_in;
            r3_q  <= r3_in;
            err_q <= bad_new;
            if (bad_new || (r3_in == '0)) st_q <= ST_FIN;
            else if (op_new == OP_FILL)   st_q <= ST_WR;
            else                          st_q <= ST_RDA;
          end
        end
        ST_RDA: begin
          if (mem_ack && !op_is_search(op_q)) begin
            hold_a <= mem_rdata;
            st_q   <= op_is_copy(op_q) ? ST_WR : ST_RDB;
          end
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: ;
      endcase
      if (elem_done) begin
        r1_q <= r1_nxt;
        r2_q <= r2_nxt;
        r3_q <= r3_nxt;
        if (stop) begin
          st_q <= ST_FIN;
          if (upd_flags) begin
            z_q <= z_val;
            c_q <= c_val;
          end
        end else begin
          st_q <= (op_q == OP_FILL) ? ST_WR : ST_RDA;
        end
      end
    end
  end

  assign busy   = (st_q != ST_IDLE);
  assign done   = (st_q == ST_FIN);
  assign err    = err_q;
  assign r1_out = r1_q;
  assign r2_out = r2_q;
  assign r3_out = r3_q;
  assign flag_z = z_q;
  assign flag_c = c_q;

endmodule

// File: rtl/strseq_checker.sv
module strseq_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [2:0]      op,
  input logic [1:0]      size,
  input logic [XLEN-1:0] r3_in,
  input logic            busy,
  input logic            done,
  input logic            err,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_ack,
  input logic [XLEN-1:0] mem_addr,
  input logic [XLEN-1:0] r3_out,
  input logic            flag_z,
  input logic            flag_c,
  input logic            elem_done,
  input logic            flag_upd
);

  logic start_idle;
  logic start_bad;
  assign start_idle = start && !busy;
  assign start_bad  = (size == 2'd3) || (op == 3'd7);

  assert_illegal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_idle && start_bad |=> done && err && !mem_req);

  assert_empty_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_idle && !start_bad && (r3_in == '0) |=> done && !err && !mem_req);

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    elem_done |=> r3_out == $past(r3_out) - XLEN'(1));

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_upd |=> $stable(flag_z) && $stable(flag_c));

endmodule

bind strseq_engine strseq_checker #(.XLEN(XLEN)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .op        (op),
  .size      (size),
  .r3_in     (r3_in),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .r3_out    (r3_out),
  .flag_z    (flag_z),
  .flag_c    (flag_c),
  .elem_done (elem_done),
  .flag_upd  (flag_upd)
);

// File: tb/strseq_engine_tb.sv
module strseq_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int XLEN       = 32;
  localparam int NVEC       = 15;

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  sz;
    logic [7:0]  r1;
    logic [31:0] r2;
    logic [7:0]  r3;
    logic [7:0]  mul;
    logic [7:0]  add;
    logic [7:0]  pa;
    logic [7:0]  pv;
    logic [7:0]  dup;
    logic [1:0]  lat;
  } vec_t;

  // op, sz, r1, r2, r3, pattern mul, pattern add, plant addr, plant value, dup length, latency
  localparam vec_t VT [NVEC] = '{
    '{3'd0, 2'd0, 8'h80, 32'h0000_0010, 8'd5,  8'd7, 8'd1,  8'hFF, 8'hFF, 8'd0, 2'd0},
    '{3'd1, 2'd0, 8'h90, 32'h0000_0030, 8'd6,  8'd3, 8'd2,  8'hFF, 8'hFF, 8'd0, 2'd1},
    '{3'd2, 2'd0, 8'h70, 32'h0000_0020, 8'd10, 8'd5, 8'd3,  8'h23, 8'h00, 8'd0, 2'd0},
    '{3'd2, 2'd0, 8'h70, 32'h0000_0020, 8'd3,  8'd5, 8'd3,  8'h28, 8'h00, 8'd0, 2'd2},
    '{3'd3, 2'd0, 8'h40, 32'h0000_00A5, 8'd4,  8'd1, 8'd0,  8'hFF, 8'hFF, 8'd0, 2'd0},
    '{3'd3, 2'd1, 8'h40, 32'h1234_BEEF, 8'd3,  8'd1, 8'd0,  8'hFF, 8'hFF, 8'd0, 2'd2},
    '{3'd3, 2'd2, 8'h44, 32'hCAFE_F00D, 8'd2,  8'd2, 8'd0,  8'hFF, 8'hFF, 8'd0, 2'd1},
    '{3'd4, 2'd0, 8'h50, 32'h0000_0055, 8'd16, 8'd1, 8'd0,  8'hFF, 8'hFF, 8'd0, 2'd0},
    '{3'd4, 2'd1, 8'h50, 32'hFFFF_0000, 8'd4,  8'd1, 8'd0,  8'hFF, 8'hFF, 8'd0, 2'd1},
    '{3'd5, 2'd0, 8'h50, 32'h0000_0011, 8'd8,  8'd0, 8'h11, 8'h53, 8'h22, 8'd0, 2'd0},
    '{3'd5, 2'd2, 8'h50, 32'h3333_3333, 8'd3,  8'd0, 8'h33, 8'hFF, 8'hFF, 8'd0, 2'd2},
    '{3'd6, 2'd0, 8'h60, 32'h0000_00A0, 8'd10, 8'd9, 8'd1,  8'h63, 8'h00, 8'd5, 2'd0},
    '{3'd6, 2'd0, 8'h60, 32'h0000_00A0, 8'd8,  8'd9, 8'd1,  8'hFF, 8'hFF, 8'd3, 2'd1},
    '{3'd6, 2'd0, 8'h60, 32'h0000_00A0, 8'd4,  8'd9, 8'd1,  8'hFF, 8'hFF, 8'd8, 2'd0},
    '{3'd4, 2'd2, 8'h50, 32'h5B5A_5958, 8'd5,  8'd1, 8'd0,  8'hFF, 8'hFF, 8'd0, 2'd0}
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic            start;
  logic [2:0]      op;
  logic [1:0]      size;
  logic [XLEN-1:0] r1_in, r2_in, r3_in;
  logic            busy, done, err;
  logic [XLEN-1:0] r1_out, r2_out, r3_out;
  logic            flag_z, flag_c;
  logic            mem_req, mem_we;
  logic [1:0]      mem_size;
  logic [XLEN-1:0] mem_addr, mem_wdata;
  logic            mem_ack;
  logic [XLEN-1:0] mem_rdata;

  logic [7:0]  mem     [256];
  logic [7:0]  ref_mem [256];
  logic [31:0] e_r1, e_r2, e_r3;
  logic        e_z, e_c, e_err;
  int          total = 0;
  int          bad   = 0;
  int          req_seen;
  logic        saw_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  strseq_engine #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .size(size),
    .r1_in(r1_in), .r2_in(r2_in), .r3_in(r3_in),
    .busy(busy), .done(done), .err(err),
    .r1_out(r1_out), .r2_out(r2_out), .r3_out(r3_out),
    .flag_z(flag_z), .flag_c(flag_c),
    .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] o);
    case (o)
      3'd0, 3'd1: return "R3";
      3'd2:       return "R4";
      3'd3:       return "R5";
      3'd4:       return "R6";
      3'd5:       return "R7";
      3'd6:       return "R8";
      default:    return "R1";
    endcase
  endfunction

  function automatic logic [31:0] ref_load(input logic [31:0] a, input logic [1:0] s);
    logic [31:0] v = '0;
    for (int k = 0; k < (1 << s); k++) v[8*k +: 8] = ref_mem[8'(a + k)];
    return v;
  endfunction

  // Independent behavioural restatement of the requirements.
  task automatic ref_exec(input logic [2:0] o, input logic [1:0] s,
                          input logic [31:0] a1, input logic [31:0] a2, input logic [31:0] n);
    logic [31:0] el;
    logic [7:0]  ba, bb;
    logic        fin;
    e_r1 = a1; e_r2 = a2; e_r3 = n;
    e_err = (s == 2'd3) || (o == 3'd7);
    if (e_err || n == 0) return;
    fin = 1'b0;
    for (int g = 0; g < 300 && !fin; g++) begin
      case (o)
        3'd0, 3'd1, 3'd2: begin
          ba = ref_mem[e_r2[7:0]];
          ref_mem[e_r1[7:0]] = ba;
          if (o == 3'd1) begin e_r1 = e_r1 - 1; e_r2 = e_r2 - 1; end
          else           begin e_r1 = e_r1 + 1; e_r2 = e_r2 + 1; end
          e_r3 = e_r3 - 1;
          fin = (e_r3 == 0) || (o == 3'd2 && ba == 8'h00);
        end
        3'd3: begin
          for (int k = 0; k < (1 << s); k++) ref_mem[8'(e_r1 + k)] = e_r2[8*k +: 8];
          e_r1 = e_r1 + (32'd1 << s);
          e_r3 = e_r3 - 1;
          fin = (e_r3 == 0);
        end
        3'd4, 3'd5: begin
          el = ref_load(e_r1, s);
          e_r1 = e_r1 + (32'd1 << s);
          e_r3 = e_r3 - 1;
          fin = (e_r3 == 0) || ((o == 3'd4) == (el == e_r2));
          if (fin) begin
            e_z = (o == 3'd4) ? (el == e_r2) : (e_r3 == 0);
            e_c = (el <= e_r2);
          end
        end
        default: begin
          ba = ref_mem[e_r1[7:0]];
          bb = ref_mem[e_r2[7:0]];
          e_r1 = e_r1 + 1; e_r2 = e_r2 + 1; e_r3 = e_r3 - 1;
          fin = (e_r3 == 0) || (ba != bb) || (ba == 8'h00);
          if (fin) begin
            e_z = (ba == bb);
            e_c = (ba >= bb);
          end
        end
      endcase
    end
  endtask

  // Drives one instruction and serves the memory port until done.
  task automatic run_dut(input logic [2:0] o, input logic [1:0] s,
                         input logic [31:0] a1, input logic [31:0] a2, input logic [31:0] n,
                         input logic [1:0] lat);
    int wcnt = 0;
    @(negedge clk);
    op = o; size = s; r1_in = a1; r2_in = a2; r3_in = n;
    start = 1'b1;
    req_seen = 0;
    saw_done = 1'b0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clk);
      start = 1'b0;
      if (done) begin saw_done = 1'b1; break; end
      if (mem_req) req_seen++;
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req) begin
        if (wcnt < int'(lat)) wcnt++;
        else begin
          wcnt = 0;
          mem_ack = 1'b1;
          mem_rdata = '0;
          for (int k = 0; k < (1 << mem_size); k++) begin
            if (mem_we) mem[8'(mem_addr + k)] = mem_wdata[8*k +: 8];
            else        mem_rdata[8*k +: 8] = mem[8'(mem_addr + k)];
          end
        end
      end
    end
  endtask

  task automatic compare_all(input string tag);
    int diffs = 0;
    check(saw_done, tag, "done seen", 32'(saw_done), 32'd1);
    check(err == e_err, tag, "err", 32'(err), 32'(e_err));
    check(r1_out == e_r1, tag, "r1", r1_out, e_r1);
    check(r2_out == e_r2, tag, "r2", r2_out, e_r2);
    check(r3_out == e_r3, tag, "r3", r3_out, e_r3);
    check(flag_z == e_z, tag, "flag_z", 32'(flag_z), 32'(e_z));
    check(flag_c == e_c, tag, "flag_c", 32'(flag_c), 32'(e_c));
    for (int i = 0; i < 256; i++) if (mem[i] != ref_mem[i]) diffs++;
    check(diffs == 0, tag, "memory bytes differing", 32'(diffs), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op = '0; size = '0;
    r1_in = '0; r2_in = '0; r3_in = '0;
    mem_ack = 1'b0; mem_rdata = '0;
    e_z = 1'b0; e_c = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check(!busy && !done && !err && !mem_req, "R10", "reset ctrl",
          {28'd0, busy, done, err, mem_req}, 32'd0);
    check(r1_out == 0 && r2_out == 0 && r3_out == 0 && !flag_z && !flag_c, "R10",
          "reset regs/flags", r1_out | r2_out | r3_out, 32'd0);
    rst_n = 1'b1;

    // Table walk: stimulus vectors, expected results from ref_exec.
    for (int v = 0; v < NVEC; v++) begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * VT[v].mul + VT[v].add);
      mem[VT[v].pa] = VT[v].pv;
      for (int j = 0; j < int'(VT[v].dup); j++)
        mem[8'(VT[v].r2[7:0] + j)] = mem[8'(VT[v].r1 + j)];
      for (int i = 0; i < 256; i++) ref_mem[i] = mem[i];
      ref_exec(VT[v].op, VT[v].sz, {24'd0, VT[v].r1}, VT[v].r2, {24'd0, VT[v].r3});
      run_dut(VT[v].op, VT[v].sz, {24'd0, VT[v].r1}, VT[v].r2, {24'd0, VT[v].r3}, VT[v].lat);
      compare_all(tag_of(VT[v].op));
    end

    // R2: zero count, no access, flags kept from the last compare.
    ref_exec(3'd0, 2'd0, 32'h10, 32'h20, 32'd0);
    run_dut(3'd0, 2'd0, 32'h10, 32'h20, 32'd0, 2'd0);
    compare_all("R2");
    check(req_seen == 0, "R2", "requests", 32'(req_seen), 32'd0);

    // R1: illegal size code 3.
    ref_exec(3'd3, 2'd3, 32'h40, 32'h77, 32'd5);
    run_dut(3'd3, 2'd3, 32'h40, 32'h77, 32'd5, 2'd0);
    compare_all("R1");
    check(req_seen == 0, "R1", "requests size3", 32'(req_seen), 32'd0);

    // R1: illegal operation code 7.
    ref_exec(3'd7, 2'd0, 32'h40, 32'h77, 32'd5);
    run_dut(3'd7, 2'd0, 32'h40, 32'h77, 32'd5, 2'd1);
    compare_all("R1");
    check(req_seen == 0, "R1", "requests op7", 32'(req_seen), 32'd0);

    // R1 err clears on next legal start; R10 fill keeps flags.
    ref_exec(3'd3, 2'd0, 32'hC0, 32'h5A, 32'd2);
    run_dut(3'd3, 2'd0, 32'hC0, 32'h5A, 32'd2, 2'd0);
    compare_all("R10");
    check(!err, "R1", "err cleared", 32'(err), 32'd0);

    // R10: done lasts one cycle.
    @(negedge clk);
    check(!done, "R10", "done pulse width", 32'(done), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule